// File: doc/BRIEF.md
# SPI Double-Buffered Data and Status Controller

This block is the host-facing data path of an 8-bit SPI controller. It has a one-entry transmit holding buffer in front of a transmit/receive shift register, a receive holding register, a control register and a read-only status register with three flags. The flags are receive-full, transmit-empty and mode-fault. Software never clears a flag directly. It reads the status register while the flag is 1, which arms that flag. The matching follow-up access then clears it: a data read for receive-full, a data write for transmit-empty, and a control write for mode-fault.

A byte written into an empty transmit buffer moves on its own into the shift register as soon as the shifter is free. That frees the buffer, so a second byte can wait behind the one being sent. A clock divider paces the shifter. Each transfer sends eight bits MSB first on `mosi_o` and samples `miso_i` on every rising `sclk_o` edge.

When host mode and fault checking are both enabled and the block is not driving its own select, a low level on the select input raises mode-fault. It also stops the transfer in progress and drops host mode.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset the status register reads 0x20 and the control register reads 0x00. Status bit 7 is receive-full, bit 5 is transmit-empty and bit 4 is mode-fault, and bits 6, 3, 2, 1 and 0 read 0. The control register keeps only bit 0 (fault check enable), bit 1 (select output enable), bit 4 (host mode) and bit 5 (transmit interrupt enable). All other control bits read 0.
- R2: Receive-full becomes 1 in the cycle after the last bit of a transfer. From that same cycle the received byte is readable on `rxdata_o`.
- R3: Receive-full clears only after a status read that saw it at 1 and a later data read. A data read without that armed status read leaves it at 1.
- R4: A data write clears transmit-empty and captures the byte only if an earlier status read saw transmit-empty at 1. Otherwise the write is dropped: transmit-empty stays 1 and no transfer starts.
- R5: With host mode on and the shifter idle, transmit-empty reads 0 in the cycle after an accepted data write and 1 again in the cycle after that, because the byte has moved into the shifter.
- R6: A byte queued while a transfer runs moves into the shifter one cycle after that transfer ends, and transmit-empty then rises. With nothing queued, transmit-empty stays 1 and no further transfer starts.
- R7: A transfer starts in the cycle after the byte moves into the shifter and lasts 16*DIV cycles. It gives exactly eight rising `sclk_o` edges, with MSB first on `mosi_o`. The received byte holds the `miso_i` values sampled at the rising edges, MSB first.
- R8: Mode-fault sets one cycle after `ss_n_i` is sampled low, but only while host mode is 1, fault check is 1 and select output enable is 0. For every other combination of these three bits it never sets.
- R9: Mode-fault clears only after a status read that saw it at 1 and a later control write. A control write without that armed status read leaves it at 1.
- R10: A mode fault clears the host mode bit in the same cycle that mode-fault sets. It also stops any running transfer: `sclk_o` returns low and receive-full is not set by the aborted transfer.
- R11: `tx_irq_o` is 1 exactly when transmit-empty is 1 and the transmit interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| ctl_wr_i | input | 1 | Control register write strobe |
| wdata_i | input | DATA_W | Write data for data and control writes |
| status_o | output | 8 | Status register value |
| rxdata_o | output | DATA_W | Receive holding register |
| ctl_o | output | 8 | Control register value |
| tx_irq_o | output | 1 | Transmit-empty interrupt request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Select output, low during a transfer when enabled |
| ss_n_i | input | 1 | Select input used for fault detection |

## Verification
The serial path runs as a loopback, either straight or inverted. Twenty byte patterns are sent through it: walking ones plus dense and alternating values. This separates bit-order and sampling-edge faults from data-path faults. Every pattern also checks the exact cycle at which each flag changes. A back-to-back pair tells the automatic refill of the shifter apart from a refill that would have to wait for software. All eight settings of the three fault-gating control bits are swept. A fault raised mid-transfer shows the abort separately from the flag itself. Unarmed data writes, data reads and control writes are each issued where they would change something if they were honoured.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    // control register bit positions
    localparam int CTL_FAULT_CHK = 0;
    localparam int CTL_SS_OUT    = 1;
    localparam int CTL_HOST      = 4;
    localparam int CTL_TXIE      = 5;
    localparam logic [7:0] CTL_MASK = 8'h33;

    // status register bit positions
    localparam int STAT_RXF  = 7;
    localparam int STAT_TXE  = 5;
    localparam int STAT_MODF = 4;

    typedef struct packed {
        logic rxf;
        logic txe;
        logic modf;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{rxf: 1'b0, txe: 1'b1, modf: 1'b0};
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int DATA_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              abort_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o,
    output logic              sclk_o,
    output logic              mosi_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              samp;
        logic [CNT_W-1:0]  div;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] sh;
    } eng_t;

    eng_t q, d;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (abort_i) begin
            d.busy = 1'b0;
            d.sclk = 1'b0;
            d.div  = '0;
            d.bits = '0;
        end else if (!q.busy) begin
            if (load_i) begin
                d.busy = 1'b1;
                d.sclk = 1'b0;
                d.div  = '0;
                d.bits = '0;
                d.sh   = load_data_i;
            end
        end else if (q.div == DIV_LAST) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.samp = miso_i;
            end else begin
                d.sclk = 1'b0;
                d.sh   = {q.sh[DATA_W-2:0], q.samp};
                if (q.bits == BIT_LAST) begin
                    done   = 1'b1;
                    d.busy = 1'b0;
                    d.bits = '0;
                end else begin
                    d.bits = q.bits + 1'b1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign done_o = done;
    assign rx_o   = {q.sh[DATA_W-2:0], q.samp};
    assign sclk_o = q.sclk;
    assign mosi_o = q.sh[DATA_W-1];

    // serial clock only toggles high while a transfer runs
    assert_sclk_rise_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sclk) |-> $past(q.busy));
    // bit counter never passes the last bit
    assert_bit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.bits <= BIT_LAST);
    // an abort leaves the serial clock low
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!q.sclk && !q.busy));
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
    import spi_dbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stat_rd_i,
    input  logic   data_rd_i,
    input  logic   data_wr_i,
    input  logic   ctl_wr_i,
    input  logic   set_rxf_i,
    input  logic   set_txe_i,
    input  logic   set_modf_i,
    output flags_t flags_o,
    output logic   wr_ok_o
);
    typedef struct packed {
        flags_t f;
        flags_t arm;
    } fu_t;

    fu_t q, d;
    logic wr_ok;

    always_comb begin
        d     = q;
        wr_ok = data_wr_i && q.arm.txe;

        // follow-up accesses consume an armed flag
        if (data_rd_i && q.arm.rxf) begin
            d.f.rxf   = 1'b0;
            d.arm.rxf = 1'b0;
        end
        if (wr_ok) begin
            d.f.txe   = 1'b0;
            d.arm.txe = 1'b0;
        end
        if (ctl_wr_i && q.arm.modf) begin
            d.f.modf   = 1'b0;
            d.arm.modf = 1'b0;
        end

        // a status read arms every flag it sees at 1
        if (stat_rd_i) begin
            if (q.f.rxf)  d.arm.rxf  = 1'b1;
            if (q.f.txe)  d.arm.txe  = 1'b1;
            if (q.f.modf) d.arm.modf = 1'b1;
        end

        // hardware set events win over clears
        if (set_rxf_i)  d.f.rxf  = 1'b1;
        if (set_txe_i)  d.f.txe  = 1'b1;
        if (set_modf_i) d.f.modf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.f   <= FLAGS_RESET;
            q.arm <= '0;
        end else begin
            q <= d;
        end
    end

    assign flags_o = q.f;
    assign wr_ok_o = wr_ok;

    assert_rxf_set_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.f.rxf) |-> $past(set_rxf_i));
    assert_rxf_clear_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.f.rxf) |-> $past(data_rd_i));
    assert_txe_clear_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.f.txe) |-> $past(data_wr_i));
    assert_modf_clear_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.f.modf) |-> $past(ctl_wr_i));
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    input  logic              data_wr_i,
    input  logic              ctl_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [7:0]        status_o,
    output logic [DATA_W-1:0] rxdata_o,
    output logic [7:0]        ctl_o,
    output logic              tx_irq_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              ss_n_o,
    input  logic              ss_n_i
);
    typedef struct packed {
        logic [7:0]        ctl;
        logic [DATA_W-1:0] txbuf;
        logic [DATA_W-1:0] rxbuf;
    } top_t;

    top_t q, d;

    flags_t            flags;
    logic              wr_ok;
    logic              host;
    logic              fault_gate;
    logic              set_modf;
    logic              load;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rx;

    always_comb begin
        host       = q.ctl[CTL_HOST];
        fault_gate = host && q.ctl[CTL_FAULT_CHK] && !q.ctl[CTL_SS_OUT];
        set_modf   = fault_gate && !ss_n_i;
        load       = host && !flags.txe && !eng_busy && !set_modf;

        d = q;
        if (ctl_wr_i) begin
            d.ctl = wdata_i[7:0] & CTL_MASK;
        end
        if (set_modf) begin
            d.ctl[CTL_HOST] = 1'b0;
        end
        if (wr_ok) begin
            d.txbuf = wdata_i;
        end
        if (eng_done) begin
            d.rxbuf = eng_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    spi_flag_unit u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd_i  (stat_rd_i),
        .data_rd_i  (data_rd_i),
        .data_wr_i  (data_wr_i),
        .ctl_wr_i   (ctl_wr_i),
        .set_rxf_i  (eng_done),
        .set_txe_i  (load),
        .set_modf_i (set_modf),
        .flags_o    (flags),
        .wr_ok_o    (wr_ok)
    );

    spi_bit_engine #(
        .DATA_W (DATA_W),
        .DIV    (DIV)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_data_i (q.txbuf),
        .abort_i     (set_modf),
        .miso_i      (miso_i),
        .busy_o      (eng_busy),
        .done_o      (eng_done),
        .rx_o        (eng_rx),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o)
    );

    always_comb begin
        status_o            = 8'h00;
        status_o[STAT_RXF]  = flags.rxf;
        status_o[STAT_TXE]  = flags.txe;
        status_o[STAT_MODF] = flags.modf;
    end

    assign rxdata_o = q.rxbuf;
    assign ctl_o    = q.ctl;
    assign tx_irq_o = flags.txe && q.ctl[CTL_TXIE];
    assign ss_n_o   = !(q.ctl[CTL_SS_OUT] && host && eng_busy);

    // fault flag only rises under the gating combination
    assert_modf_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.modf) |-> $past(fault_gate));
    // host mode is gone when the fault flag appears
    assert_modf_drops_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.modf) |-> !q.ctl[CTL_HOST]);
    // transmit-empty only returns once the shifter has taken the byte
    assert_txe_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.txe) |-> eng_busy);
    // received byte changes only at the end of a transfer
    assert_rx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eng_done) |-> $stable(q.rxbuf));
endmodule

// File: tb/test_spi_dbuf_ctrl.sv
module test_spi_dbuf_ctrl;
    localparam int DIV  = 2;
    localparam int XFER = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stat_rd, data_rd, data_wr, ctl_wr;
    logic [7:0] wdata;
    logic [7:0] status, rxdata, ctl;
    logic       tx_irq, sclk, mosi, miso, ss_n_o, ss_n_i;
    logic       inv;

    int checks = 0;
    int errors = 0;
    int rises  = 0;
    logic [7:0] cap = 8'h00;

    always #5 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_dbuf_ctrl #(.DATA_W(8), .DIV(DIV)) i_spi_dbuf_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd_i (stat_rd),
        .data_rd_i (data_rd),
        .data_wr_i (data_wr),
        .ctl_wr_i  (ctl_wr),
        .wdata_i   (wdata),
        .status_o  (status),
        .rxdata_o  (rxdata),
        .ctl_o     (ctl),
        .tx_irq_o  (tx_irq),
        .sclk_o    (sclk),
        .mosi_o    (mosi),
        .miso_i    (miso),
        .ss_n_o    (ss_n_o),
        .ss_n_i    (ss_n_i)
    );

    always @(posedge sclk) begin
        rises = rises + 1;
        cap   = {cap[6:0], mosi};
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic do_rd();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] v);
        wdata   = v;
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic do_ctl(input logic [7:0] v);
        wdata  = v;
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        stat_rd = 0; data_rd = 0; data_wr = 0; ctl_wr = 0;
        wdata = 8'h00; ss_n_i = 1'b1; inv = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "status reset", status, 8'h20);
        chk("R1", "control reset", ctl, 8'h00);
        chk("R1", "sclk idle", sclk, 0);
        chk("R11", "irq reset", tx_irq, 0);

        // R1 control register keeps only defined bits
        do_ctl(8'hFF);
        chk("R1", "control mask", ctl, 8'h33);
        do_ctl(8'h10);

        // R4 unarmed write is dropped
        begin
            int r0 = rises;
            do_wr(8'h3C);
            chk("R4", "unarmed write txe", status, 8'h20);
            repeat (XFER + 4) @(negedge clk);
            chk("R4", "unarmed write no transfer", rises - r0, 0);
            chk("R4", "unarmed write no rxf", status, 8'h20);
        end

        // R11 interrupt request follows txe and enable
        do_ctl(8'h30);
        chk("R11", "irq enabled txe=1", tx_irq, 1);
        do_ctl(8'h10);
        chk("R11", "irq disabled", tx_irq, 0);
        do_ctl(8'h30);

        // R2 R3 R5 R7 pattern sweep through loopback
        for (int i = 0; i < 20; i++) begin
            logic [7:0] pat;
            logic [7:0] expect_rx;
            int r0;
            case (i)
                8:  pat = 8'h00;  9:  pat = 8'hFF;  10: pat = 8'hA5;  11: pat = 8'h5A;
                12: pat = 8'h3C;  13: pat = 8'hC3;  14: pat = 8'h81;  15: pat = 8'h7E;
                16: pat = 8'h0F;  17: pat = 8'hF0;  18: pat = 8'h96;  19: pat = 8'h69;
                default: pat = 8'h01 << i;
            endcase
            inv = i[0];
            expect_rx = inv ? ~pat : pat;
            do_stat();
            r0 = rises;
            do_wr(pat);
            chk("R4", "armed write clears txe", status, 8'h00);
            chk("R11", "irq low while buffer full", tx_irq, 0);
            @(negedge clk);
            chk("R5", "byte moved to shifter", status, 8'h20);
            repeat (XFER - 1) @(negedge clk);
            chk("R7", "no rxf before last bit", status, 8'h20);
            @(negedge clk);
            chk("R2", "rxf after transfer", status, 8'hA0);
            chk("R7", "received byte", rxdata, expect_rx);
            chk("R7", "transmitted byte msb first", cap, pat);
            chk("R7", "eight clock edges", rises - r0, 8);
            do_rd();
            chk("R3", "unarmed read keeps rxf", status, 8'hA0);
            do_stat();
            do_rd();
            chk("R3", "armed read clears rxf", status, 8'h20);
        end
        inv = 1'b0;

        // R6 queued second byte
        begin
            int r0;
            do_ctl(8'h10);
            do_stat();
            r0 = rises;
            do_wr(8'hC5);                  // cycle 1 after this
            do_stat();                     // txe=0, no arm; cycle 2
            do_stat();                     // txe=1, arms; cycle 3
            do_wr(8'h1E);                  // cycle 4
            chk("R6", "buffer full", status, 8'h00);
            repeat (XFER - 3) @(negedge clk);
            chk("R6", "still full before end", status, 8'h00);
            @(negedge clk);
            chk("R6", "first done, buffer still full", status, 8'h80);
            chk("R6", "first byte received", rxdata, 8'hC5);
            chk("R6", "first byte sent", cap, 8'hC5);
            @(negedge clk);
            chk("R6", "queued byte moved", status, 8'hA0);
            repeat (XFER - 1) @(negedge clk);
            chk("R6", "second not done yet", rxdata, 8'hC5);
            @(negedge clk);
            chk("R6", "second byte received", rxdata, 8'h1E);
            chk("R6", "second byte sent", cap, 8'h1E);
            chk("R6", "sixteen clock edges", rises - r0, 16);
            repeat (XFER + 2) @(negedge clk);
            chk("R6", "nothing queued, no transfer", rises - r0, 16);
            chk("R6", "txe stays set", status, 8'hA0);
            do_stat();
            do_rd();
            chk("R3", "cleared after pair", status, 8'h20);
        end

        // R8 R9 R10 sweep of gating bits
        for (int cfg = 0; cfg < 8; cfg++) begin
            logic [7:0] cv;
            logic       hit;
            cv  = {3'b000, cfg[2], 2'b00, cfg[1], cfg[0]};
            hit = (cfg == 5);
            do_ctl(cv);
            ss_n_i = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk("R8", "mode fault gating", status, hit ? 8'h30 : 8'h20);
            chk("R10", "host bit after fault", ctl, hit ? (cv & 8'hEF) : cv);
            ss_n_i = 1'b1;
            if (hit) begin
                do_ctl(cv);
                chk("R9", "unarmed control write keeps fault", status, 8'h30);
                do_stat();
                do_ctl(8'h00);
                chk("R9", "armed control write clears fault", status, 8'h20);
            end else begin
                do_ctl(8'h00);
            end
        end

        // R10 abort mid-transfer
        begin
            int r0;
            do_ctl(8'h11);
            do_stat();
            r0 = rises;
            do_wr(8'h5B);
            repeat (9) @(negedge clk);
            ss_n_i = 1'b0;
            @(negedge clk);
            ss_n_i = 1'b1;
            chk("R10", "fault during transfer", status, 8'h30);
            chk("R10", "host cleared", ctl, 8'h01);
            repeat (XFER + 4) @(negedge clk);
            chk("R10", "no rxf from aborted transfer", status, 8'h30);
            chk("R10", "sclk low after abort", sclk, 0);
            chk("R10", "transfer cut short", (rises - r0) < 8, 1);
            do_stat();
            do_ctl(8'h00);
            chk("R9", "fault cleared after abort", status, 8'h20);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule